// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the interrupt side of an SMBus target. It keeps a sticky status word that picks up its live condition inputs on every monitoring pulse. It drives an active-low, open-drain alert line whenever an enabled condition needs attention. It also answers the host's alert-response read with the device's own address, so the host can find out which target raised the alert.

The host learns about the alert from the alert line. It then starts a read to the alert response address, 7'b0001100 with the read bit set. The block acknowledges that read only while its alert is raised, and returns its 7-bit address in bits 7:1 with bit 0 cleared. Several targets can answer at once. Each one watches SDA while it sends, and a target that releases the line for a 1 but sees a 0 drops out. The lowest address therefore wins. Reading the status word clears it. The alert line goes inactive only when the enabled conditions behind it have gone away.

SCL and SDA arrive as raw bus levels and pass through a configurable synchronizer. The block never holds SCL low. Its only bus output is a pull-down request for SDA.

Top module: `smbus_alert_responder`

## Requirements
- R1: Out of reset the status word, the read-data register, the alert pull and the SDA pull are all 0. The alert is raised only at a monitor_tick pulse.
- R2: On the clock edge where monitor_tick is 1 and (cond_in & irq_mask) is nonzero, alert_pull_low becomes 1.
- R3: monitor_tick ORs cond_in into the status word. A status bit stays set after its condition drops, until the word is read.
- R4: When stat_rd is 1, stat_rdata captures the status word on that edge and the word is cleared. If monitor_tick is 1 on the same edge, the word is loaded with cond_in instead.
- R5: A condition bit whose irq_mask bit is 0 still sets its status bit, but it neither raises the alert nor holds it.
- R6: While (cond_in & irq_mask) is nonzero, alert_pull_low stays 1. It drops once both (status & irq_mask) and (cond_in & irq_mask) are zero, so a status read alone does not release it.
- R7: A byte of 8'h19 (address 0001100 followed by read bit 1) after a START, with the alert raised, is acknowledged: SDA is pulled low during the ninth SCL pulse.
- R8: The block does not acknowledge the alert address with the write bit (8'h18), and it does not acknowledge any address while its alert is inactive.
- R9: After the acknowledge, the block sends {dev_addr, 1'b0} MSB first. Each bit is changed while SCL is low.
- R10: If the block leaves SDA released to send a 1 and samples SDA low at the SCL rise, it stops driving for the rest of the transfer and keeps its alert raised.
- R11: After sending all eight bits and seeing the host's NACK (SDA high on the ninth pulse), the block drops its alert if (cond_in & irq_mask) is zero. Otherwise the alert stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| dev_addr | input | 7 | This target's 7-bit bus address |
| cond_in | input | WIDTH | Live condition inputs |
| irq_mask | input | WIDTH | 1 enables a condition to drive the alert |
| monitor_tick | input | 1 | One-cycle pulse per monitoring cycle |
| stat_rd | input | 1 | Status read strobe (clears the word) |
| stat_rdata | output | WIDTH | Status value captured by the last read |
| alert_pull_low | output | 1 | 1 pulls the open-drain alert line low |
| sda_pull_low | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach is losing arbitration. It needs a second target driving the wired-AND SDA line during the returned byte, and that target must carry 1 bits in positions where this block sends 0 after the point where the two diverge. The bench models a lower-addressed competitor (returned byte 8'h46 against 8'h54). Any further drive from the block after the loss would then corrupt the byte the host reads. Alert release after a NACK is reached twice: once with the condition still active and once with it gone.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_ACKHOLD, ST_DATA, ST_MACK, ST_WAIT
  } ara_state_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;
endpackage

// File: rtl/ara_bus_watch.sv
module ara_bus_watch
  import alert_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_in,
  input  logic     sda_in,
  output logic     scl_s,
  output logic     sda_s,
  output bus_evt_t evt
);
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_s <= 1'b1;
          sda_s <= 1'b1;
        end else begin
          scl_s <= scl_in;
          sda_s <= sda_in;
        end
      end
    end else begin : g_many
      logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
        end
      end
      assign scl_s = scl_pipe[SYNC_STAGES-1];
      assign sda_s = sda_pipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    evt.rise  = scl_s & ~scl_p;
    evt.fall  = ~scl_s & scl_p;
    evt.start = scl_s & scl_p & sda_p & ~sda_s;
    evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
  end
endmodule

// File: rtl/ara_responder.sv
module ara_responder
  import alert_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_evt_t   evt,
  input  logic       sda_s,
  input  logic       alert_active,
  input  logic [6:0] dev_addr,
  output logic       sda_pull_low,
  output logic       win_nack
);
  localparam int CNT_W = 4;

  ara_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [6:0]       shreg;
  logic [7:0]       tx;
  logic [7:0]       rx_byte;

  assign rx_byte = {shreg, sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      tx           <= '0;
      sda_pull_low <= 1'b0;
      win_nack     <= 1'b0;
    end else begin
      win_nack <= 1'b0;
      if (evt.start) begin
        state        <= ST_ADDR;
        cnt          <= '0;
        sda_pull_low <= 1'b0;
      end else if (evt.stop) begin
        state        <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (evt.rise) begin
            shreg <= rx_byte[6:0];
            if (cnt == CNT_W'(7)) begin
              cnt <= '0;
              if (rx_byte == {ARA_ADDR, 1'b1} && alert_active) begin
                state <= ST_ACK;
                tx    <= {dev_addr, 1'b0};
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK: if (evt.fall) begin
            sda_pull_low <= 1'b1;
            state        <= ST_ACKHOLD;
          end
          ST_ACKHOLD: if (evt.fall) begin
            sda_pull_low <= ~tx[7];
            tx           <= {tx[6:0], 1'b0};
            cnt          <= '0;
            state        <= ST_DATA;
          end
          ST_DATA: begin
            if (evt.rise) begin
              if (!sda_pull_low && !sda_s) begin
                state        <= ST_WAIT;
                sda_pull_low <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (evt.fall) begin
              if (cnt == CNT_W'(8)) begin
                sda_pull_low <= 1'b0;
                state        <= ST_MACK;
              end else begin
                sda_pull_low <= ~tx[7];
                tx           <= {tx[6:0], 1'b0};
              end
            end
          end
          ST_MACK: if (evt.rise) begin
            win_nack <= sda_s;
            state    <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/alert_status.sv
module alert_status #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cond_in,
  input  logic [WIDTH-1:0] irq_mask,
  input  logic             monitor_tick,
  input  logic             stat_rd,
  input  logic             win_nack,
  output logic [WIDTH-1:0] stat_rdata,
  output logic [WIDTH-1:0] stat_level,
  output logic             alert_q
);
  logic cond_act, stat_act;

  assign cond_act = |(cond_in & irq_mask);
  assign stat_act = |(stat_level & irq_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_level <= '0;
      stat_rdata <= '0;
      alert_q    <= 1'b0;
    end else begin
      if (stat_rd) stat_rdata <= stat_level;
      stat_level <= (stat_rd ? '0 : stat_level) | (monitor_tick ? cond_in : '0);
      if (monitor_tick && cond_act)
        alert_q <= 1'b1;
      else if (!cond_act && (win_nack || !stat_act))
        alert_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smbus_alert_responder.sv
module smbus_alert_responder
  import alert_resp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [6:0]       dev_addr,
  input  logic [WIDTH-1:0] cond_in,
  input  logic [WIDTH-1:0] irq_mask,
  input  logic             monitor_tick,
  input  logic             stat_rd,
  output logic [WIDTH-1:0] stat_rdata,
  output logic             alert_pull_low,
  output logic             sda_pull_low
);
  bus_evt_t         evt;
  logic             scl_s, sda_s;
  logic             win_nack;
  logic [WIDTH-1:0] stat_level;

  ara_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
  );

  ara_responder u_resp (
    .clk(clk), .rst(rst), .evt(evt), .sda_s(sda_s),
    .alert_active(alert_pull_low), .dev_addr(dev_addr),
    .sda_pull_low(sda_pull_low), .win_nack(win_nack)
  );

  alert_status #(.WIDTH(WIDTH)) u_stat (
    .clk(clk), .rst(rst), .cond_in(cond_in), .irq_mask(irq_mask),
    .monitor_tick(monitor_tick), .stat_rd(stat_rd), .win_nack(win_nack),
    .stat_rdata(stat_rdata), .stat_level(stat_level), .alert_q(alert_pull_low)
  );
endmodule

// File: rtl/alert_resp_checks.sv
module alert_resp_checks #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] cond_in,
  input logic [WIDTH-1:0] irq_mask,
  input logic             monitor_tick,
  input logic             stat_rd,
  input logic [WIDTH-1:0] stat_rdata,
  input logic [WIDTH-1:0] stat_level,
  input logic             alert_pull_low
);
  assert_alert_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (monitor_tick && |(cond_in & irq_mask)) |=> alert_pull_low);

  assert_alert_rises_at_tick_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_pull_low) |-> $past(monitor_tick));

  assert_alert_held_R6: assert property (@(posedge clk) disable iff (rst)
    (alert_pull_low && |(cond_in & irq_mask)) |=> alert_pull_low);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !monitor_tick) |=> (stat_level == '0));

  assert_read_captures_R4: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_rdata == $past(stat_level)));
endmodule

bind smbus_alert_responder alert_resp_checks #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .cond_in(cond_in), .irq_mask(irq_mask),
  .monitor_tick(monitor_tick), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
  .stat_level(stat_level), .alert_pull_low(alert_pull_low)
);

// File: tb/sim_smbus_alert_responder.sv
module sim_smbus_alert_responder;
  localparam int WIDTH = 8;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1, oth_pull = 1'b0;
  logic [WIDTH-1:0] cond = '0, mask = '1;
  logic tick = 1'b0, rd = 1'b0;
  logic [WIDTH-1:0] rdata;
  logic alert, pull;
  wire  sda_bus = sda_m & ~pull & ~oth_pull;
  int   errors = 0, checks = 0;

  always #10 clk = ~clk;

  smbus_alert_responder #(.WIDTH(WIDTH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .dev_addr(MY_ADDR),
    .cond_in(cond), .irq_mask(mask), .monitor_tick(tick), .stat_rd(rd),
    .stat_rdata(rdata), .alert_pull_low(alert), .sda_pull_low(pull)
  );

  // {cond, mask, tick, rd, expected rdata, expected alert}
  localparam logic [26:0] VEC [0:12] = '{
    {8'h00, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0},  // R1 tick, nothing active
    {8'h05, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0},  // R1 no tick, no alert
    {8'h05, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b1},  // R2
    {8'h00, 8'hFF, 1'b0, 1'b1, 8'h05, 1'b0},  // R4 R6
    {8'h02, 8'hFF, 1'b1, 1'b0, 8'h05, 1'b1},  // R2
    {8'h02, 8'hFF, 1'b0, 1'b1, 8'h02, 1'b1},  // R6 read keeps alert
    {8'h02, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b1},  // R4 read+tick
    {8'h00, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b1},  // R3 sticky
    {8'h00, 8'hFF, 1'b0, 1'b1, 8'h02, 1'b0},  // R3 R6
    {8'h10, 8'hEF, 1'b1, 1'b0, 8'h02, 1'b0},  // R5 masked
    {8'h00, 8'hEF, 1'b0, 1'b1, 8'h10, 1'b0},  // R5 bit still recorded
    {8'h81, 8'h80, 1'b1, 1'b0, 8'h10, 1'b1},  // R2 R5
    {8'h01, 8'h80, 1'b0, 1'b1, 8'h81, 1'b0}   // R5 R6
  };

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; w(5); scl = 1'b1; w(5); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; w(5); scl = 1'b1; w(3); b = sda_bus; w(2); scl = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl = 1'b1; w(5); sda_m = 1'b0; w(5); scl = 1'b0; w(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(5); scl = 1'b1; w(5); sda_m = 1'b1; w(8);
  endtask

  task automatic txn(input logic [7:0] abyte, input logic [7:0] comp, input logic comp_en,
                     output logic acked, output logic [7:0] val);
    logic b;
    val = '0;
    bus_start();
    for (int i = 7; i >= 0; i--) bit_out(abyte[i]);
    bit_in(b);
    acked = ~b;
    if (acked) begin
      for (int i = 7; i >= 0; i--) begin
        oth_pull = comp_en & ~comp[i];
        bit_in(b);
        val[i] = b;
      end
      oth_pull = 1'b0;
      bit_out(1'b1);
    end
    bus_stop();
  endtask

  task automatic pulse_tick;
    tick = 1'b1; w(1); tick = 1'b0; w(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic acked;
    logic [7:0] val;
    w(3); rst = 1'b0; w(1);
    chk("R1 reset alert", alert, 0);
    chk("R1 reset sda", pull, 0);
    chk("R1 reset rdata", rdata, 0);

    for (int v = 0; v < 13; v++) begin
      {cond, mask, tick, rd} = VEC[v][26:9];
      w(1); tick = 1'b0; rd = 1'b0; w(1);
      chk($sformatf("R3/R4 vec%0d rdata", v), rdata, VEC[v][8:1]);
      chk($sformatf("R5/R6 vec%0d alert", v), alert, VEC[v][0]);
    end

    mask = 8'hFF; cond = 8'h04; pulse_tick();
    chk("R2 alert raised", alert, 1);

    txn(8'h18, 8'h00, 1'b0, acked, val);
    chk("R8 write to alert address not acked", acked, 0);

    txn(8'h19, 8'h00, 1'b0, acked, val);
    chk("R7 alert read acked", acked, 1);
    chk("R9 returned address byte", val, {MY_ADDR, 1'b0});
    chk("R11 alert held, condition active", alert, 1);

    cond = 8'h00; w(2);
    txn(8'h19, 8'h00, 1'b0, acked, val);
    chk("R7 second alert read acked", acked, 1);
    chk("R9 second address byte", val, {MY_ADDR, 1'b0});
    chk("R11 alert released after NACK", alert, 0);

    txn(8'h19, 8'h00, 1'b0, acked, val);
    chk("R8 no ack without alert", acked, 0);

    cond = 8'h08; pulse_tick(); cond = 8'h00; w(2);
    chk("R2 alert raised again", alert, 1);
    txn(8'h19, 8'h46, 1'b1, acked, val);
    chk("R7 acked before contention", acked, 1);
    chk("R10 competitor byte intact", val, 8'h46);
    chk("R10 sda released", pull, 0);
    chk("R10 alert kept after loss", alert, 1);

    rd = 1'b1; w(1); rd = 1'b0; w(2);
    chk("R3 accumulated status", rdata, 8'h0C);
    chk("R6 alert released after read", alert, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule